// File: doc/BRIEF.md
# File-Addressed Link Master

This block is the sending half of a link port in a switched storage fabric. Packets arrive as a stream of 10-bit tokens. The first token is a header that names a file, not a destination. Payload tokens follow, and a marker token closes the packet. The block looks the file up in a small table that a supervising controller writes, which gives a memory-port index. It then holds a connection request toward the arbiter until a grant comes back. With the grant in hand it passes every token through a ready/valid output, and after the closing marker it pulses a release so the arbiter can free the path.

Because the table chooses the destination, memory can be remapped without any change at the packet sources. The supervisor has two ways to act at run time. It can rewrite a table entry, which affects later headers only. It can also cut the current packet short: the block then closes the output with an error marker, frees the connection and drops the rest of the packet at its input. A header that hits an unmapped entry is consumed silently and reported on a one-cycle error pulse.

Top module: `file_link_master`

## Requirements
- R1: After synchronous reset, arb_req, arb_release, out_valid and err_miss are low, and every table entry is unmapped.
- R2: A write with cfg_we high stores cfg_ok and cfg_port for entry cfg_file. A header token has bit 9 low and carries the file number in bits [3:0]. For a mapped entry, that header leads to arb_dest equal to the stored port while arb_req is high.
- R3: A token with bit 9 high is a marker and ends a packet. Low byte 0x00 means a normal end and 0x01 an error end (0x201 as a whole token). An incoming marker of either kind is forwarded unchanged and closes the connection.
- R4: arb_req stays high with a constant arb_dest until arb_grant, and out_valid stays low until a grant has been taken.
- R5: The header, the payload and the end marker leave on out_token unchanged and in arrival order. A token held back by out_ready low stays on the output without change, and no token is lost or repeated.
- R6: Once the end marker has been accepted at the output, arb_release is high for exactly one cycle. The block then takes the next header.
- R7: A header that hits an unmapped entry raises err_miss for one cycle and issues no request. The block consumes the packet through its end marker and produces no output.
- R8: A table write changes only headers looked up after the write cycle. A packet already in flight keeps its destination, and a write in the same cycle as a lookup still gives the old value to that lookup.
- R9: A sup_abort pulse while streaming ends the output with token 0x201, pulses arb_release once that token is accepted, and consumes the input through the packet's end marker.
- R10: A sup_abort in the same cycle as the end marker's output handshake has no effect: the packet ends normally and no error marker is sent.
- R11: A sup_abort while the request is waiting withdraws arb_req with no release and no output, and discards the packet. If arb_grant arrives in that same cycle, the block sends only 0x201 and then releases.
- R12: A marker token that arrives when no packet is open is consumed with no output and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input token present |
| in_ready | output | 1 | Input token taken this cycle |
| in_token | input | 10 | Input token |
| cfg_we | input | 1 | Table write strobe |
| cfg_file | input | 4 | Table entry to write |
| cfg_ok | input | 1 | Entry mapped flag to store |
| cfg_port | input | 3 | Memory-port index to store |
| sup_abort | input | 1 | Abort the current packet |
| arb_req | output | 1 | Connection request |
| arb_dest | output | 3 | Requested memory port |
| arb_grant | input | 1 | Arbiter grant |
| arb_release | output | 1 | One-cycle connection release |
| out_valid | output | 1 | Output token present |
| out_ready | input | 1 | Downstream accepts token |
| out_token | output | 10 | Output token |
| err_miss | output | 1 | Header hit an unmapped entry |

## Verification
Two of the block's functions can fall in the same cycle: the supervisor abort and the natural end of the packet. They are forced together by stalling the output on the end marker, then dropping the stall and raising sup_abort in the same cycle. The bench counts the result as correct only if the normal marker goes out, no 0x201 follows, and exactly one release is seen. The same method covers an abort that lands on the grant cycle and a table write that lands on the lookup cycle; in each case the bench checks the port that was used, or the output tokens, against the ordering the requirements fix.

// File: rtl/vlm_pkg.sv
package vlm_pkg;

    localparam int TOK_W    = 10;
    localparam int CODE_W   = 8;
    localparam int MARK_BIT = TOK_W - 1;

    localparam logic [CODE_W-1:0] END_NORMAL = 8'h00;
    localparam logic [CODE_W-1:0] END_ERROR  = 8'h01;

    typedef logic [TOK_W-1:0] token_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_REQUEST,
        ST_STREAM,
        ST_RELEASE,
        ST_DISCARD
    } lm_state_e;

    function automatic token_t make_marker(input logic [CODE_W-1:0] code);
        return {1'b1, {(TOK_W-1-CODE_W){1'b0}}, code};
    endfunction

endpackage

// File: rtl/remap_table.sv
module remap_table #(
    parameter int FILE_W = 4,
    parameter int PORT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [FILE_W-1:0] wr_idx,
    input  logic              wr_ok,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [FILE_W-1:0] rd_idx,
    output logic              rd_ok,
    output logic [PORT_W-1:0] rd_port
);
    localparam int DEPTH = 1 << FILE_W;

    logic [DEPTH-1:0]  ok_vec;
    logic [PORT_W-1:0] port_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic              ok_r;
        logic [PORT_W-1:0] port_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                ok_r   <= 1'b0;
                port_r <= '0;
            end else if (wr_en && wr_idx == FILE_W'(g)) begin
                ok_r   <= wr_ok;
                port_r <= wr_port;
            end
        end
        assign ok_vec[g]   = ok_r;
        assign port_arr[g] = port_r;
    end

    assign rd_ok   = ok_vec[rd_idx];
    assign rd_port = port_arr[rd_idx];

endmodule

// File: rtl/link_fsm.sv
module link_fsm
    import vlm_pkg::*;
#(
    parameter int FILE_W = 4,
    parameter int PORT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_seen,
    input  logic [FILE_W-1:0] hdr_file,
    input  logic              in_end,
    input  logic              out_done,
    input  logic              abort,
    input  logic              ent_ok,
    input  logic [PORT_W-1:0] ent_port,
    input  logic              grant,
    output lm_state_e         state,
    output logic              aborted,
    output logic [FILE_W-1:0] look_idx,
    output logic              arb_req,
    output logic [PORT_W-1:0] arb_dest,
    output logic              arb_release,
    output logic              err_miss
);
    lm_state_e         state_q;
    logic              ab_q;
    logic [FILE_W-1:0] file_q;
    logic [PORT_W-1:0] dest_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ab_q    <= 1'b0;
            file_q  <= '0;
            dest_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (hdr_seen) begin
                    file_q  <= hdr_file;
                    state_q <= ST_LOOKUP;
                end
                ST_LOOKUP: begin
                    dest_q  <= ent_port;
                    ab_q    <= 1'b0;
                    state_q <= ent_ok ? ST_REQUEST : ST_DISCARD;
                end
                ST_REQUEST: if (grant) begin
                    ab_q    <= abort;
                    state_q <= abort ? ST_RELEASE : ST_STREAM;
                end else if (abort) begin
                    state_q <= ST_DISCARD;
                end
                ST_STREAM: if (in_end) begin
                    ab_q    <= 1'b0;
                    state_q <= ST_RELEASE;
                end else if (abort) begin
                    ab_q    <= 1'b1;
                    state_q <= ST_RELEASE;
                end
                ST_RELEASE: if (!ab_q || out_done) begin
                    state_q <= ab_q ? ST_DISCARD : ST_IDLE;
                end
                ST_DISCARD: if (in_end) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state       = state_q;
    assign aborted     = ab_q;
    assign look_idx    = file_q;
    assign arb_req     = (state_q == ST_REQUEST);
    assign arb_dest    = dest_q;
    assign arb_release = (state_q == ST_RELEASE) && (!ab_q || out_done);
    assign err_miss    = (state_q == ST_LOOKUP) && !ent_ok;

    // R4: a pending request keeps its destination until granted or aborted
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        arb_req && !grant && !abort |=> arb_req && $stable(arb_dest));

    // R7: an unmapped header never leads to a request
    assert_miss_no_req_R7: assert property (@(posedge clk) disable iff (rst)
        err_miss |=> !arb_req);

    // R6: the release is a single-cycle pulse
    assert_release_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        arb_release |=> !arb_release);

endmodule

// File: rtl/tok_path.sv
module tok_path
    import vlm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lm_state_e state,
    input  logic      aborted,
    input  logic      in_valid,
    input  token_t    in_tok,
    input  logic      out_ready,
    output logic      in_ready,
    output logic      out_valid,
    output token_t    out_tok,
    output logic      in_end,
    output logic      out_done
);
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_tok   = in_tok;
        unique case (state)
            ST_IDLE:    in_ready = in_valid && in_tok[MARK_BIT];
            ST_STREAM: begin
                out_valid = in_valid;
                in_ready  = out_ready;
            end
            ST_RELEASE: if (aborted) begin
                out_valid = 1'b1;
                out_tok   = make_marker(END_ERROR);
            end
            ST_DISCARD: in_ready = 1'b1;
            default: ;
        endcase
    end

    assign in_end   = in_valid && in_ready && in_tok[MARK_BIT];
    assign out_done = out_valid && out_ready;

    // R5: an input token is only taken when the output side can pass it on
    assert_pass_through_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && out_valid |-> out_ready);

endmodule

// File: rtl/file_link_master.sv
module file_link_master
    import vlm_pkg::*;
#(
    parameter int FILE_W = 4,
    parameter int PORT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TOK_W-1:0]  in_token,
    input  logic              cfg_we,
    input  logic [FILE_W-1:0] cfg_file,
    input  logic              cfg_ok,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic              sup_abort,
    output logic              arb_req,
    output logic [PORT_W-1:0] arb_dest,
    input  logic              arb_grant,
    output logic              arb_release,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TOK_W-1:0]  out_token,
    output logic              err_miss
);
    lm_state_e         state;
    logic              aborted;
    logic [FILE_W-1:0] look_idx;
    logic              ent_ok;
    logic [PORT_W-1:0] ent_port;
    logic              in_end;
    logic              out_done;
    logic              hdr_seen;

    assign hdr_seen = in_valid && !in_token[MARK_BIT];

    remap_table #(.FILE_W(FILE_W), .PORT_W(PORT_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_file),
        .wr_ok   (cfg_ok),
        .wr_port (cfg_port),
        .rd_idx  (look_idx),
        .rd_ok   (ent_ok),
        .rd_port (ent_port)
    );

    link_fsm #(.FILE_W(FILE_W), .PORT_W(PORT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .hdr_seen    (hdr_seen),
        .hdr_file    (in_token[FILE_W-1:0]),
        .in_end      (in_end),
        .out_done    (out_done),
        .abort       (sup_abort),
        .ent_ok      (ent_ok),
        .ent_port    (ent_port),
        .grant       (arb_grant),
        .state       (state),
        .aborted     (aborted),
        .look_idx    (look_idx),
        .arb_req     (arb_req),
        .arb_dest    (arb_dest),
        .arb_release (arb_release),
        .err_miss    (err_miss)
    );

    tok_path u_path (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .aborted   (aborted),
        .in_valid  (in_valid),
        .in_tok    (in_token),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_tok   (out_token),
        .in_end    (in_end),
        .out_done  (out_done)
    );

    // connection tracker seen from the arbiter ports
    logic conn_q;
    always_ff @(posedge clk) begin
        if (rst)                        conn_q <= 1'b0;
        else if (arb_release)           conn_q <= 1'b0;
        else if (arb_req && arb_grant)  conn_q <= 1'b1;
    end

    // R4: nothing is sent without a granted connection
    assert_out_needs_grant_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> conn_q);

    // R8: the destination is frozen while a connection is held
    assert_dest_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        conn_q |-> $stable(arb_dest));

    // R5: a stalled token stays unchanged unless the packet is aborted
    assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !sup_abort |=> out_valid && $stable(out_token));

endmodule

// File: tb/tb_file_link_master.sv
module tb_file_link_master;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_ready;
    logic [3:0] cfg_file = '0;
    logic       cfg_we = 1'b0, cfg_ok = 1'b0, sup_abort = 1'b0;
    logic [2:0] cfg_port = '0;
    logic       arb_req, arb_release, out_valid, err_miss;
    logic [2:0] arb_dest;
    logic [9:0] out_token;

    logic [9:0] src [256];
    int         src_n = 0, src_idx = 0;
    logic [9:0] pk [32];
    int         pk_n = 0;
    logic [9:0] obuf [256];
    int         out_cnt = 0, gcnt = 0, rcnt = 0, ecnt = 0, cyc = 0;
    logic [2:0] gdest = '0;
    int         stall_at = -1;
    logic       gnt_en = 1'b1, tog = 1'b0;
    int         nchk = 0, nfail = 0;
    bit         done = 0;

    wire in_valid  = (src_idx != src_n);
    wire [9:0] in_token = src[src_idx[7:0]];
    wire out_ready = (out_cnt != stall_at) && !(tog && cyc[0]);
    wire arb_grant = gnt_en && arb_req;

    localparam logic [9:0] EOP = 10'h200;
    localparam logic [9:0] EEP = 10'h201;

    // vectors: [11:8] file, [7:4] payload count, [1] delayed grant, [0] ready toggling
    localparam logic [11:0] VEC [8] = '{12'h010, 12'h341, 12'h702, 12'hB33,
                                        12'hC20, 12'hF00, 12'h561, 12'h922};

    file_link_master dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_token(in_token), .cfg_we(cfg_we), .cfg_file(cfg_file), .cfg_ok(cfg_ok),
        .cfg_port(cfg_port), .sup_abort(sup_abort), .arb_req(arb_req),
        .arb_dest(arb_dest), .arb_grant(arb_grant), .arb_release(arb_release),
        .out_valid(out_valid), .out_ready(out_ready), .out_token(out_token),
        .err_miss(err_miss)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (arb_req && arb_grant) begin gdest <= arb_dest; gcnt <= gcnt + 1; end
            if (arb_release) rcnt <= rcnt + 1;
            if (err_miss) ecnt <= ecnt + 1;
            if (out_valid && out_ready) begin
                obuf[out_cnt[7:0]] <= out_token;
                out_cnt <= out_cnt + 1;
            end
            if (in_valid && in_ready) src_idx <= src_idx + 1;
        end
    end

    function automatic logic [2:0] port_of(input int f);
        return 3'((f * 5 + 1) % 8);
    endfunction

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int f, input logic ok, input logic [2:0] p);
        cfg_we = 1'b1; cfg_file = 4'(f); cfg_ok = ok; cfg_port = p;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic load_pkt(input int f, input int np, input int tag, input logic [9:0] endt);
        pk[0] = {1'b0, 5'(tag), 4'(f)};
        for (int i = 0; i < np; i++) pk[1 + i] = {1'b0, 9'(tag * 16 + i + 1)};
        pk[np + 1] = endt;
        pk_n = np + 2;
        for (int i = 0; i < pk_n; i++) src[8'(src_n + i)] = pk[i];
        src_n = src_n + pk_n;
    endtask

    task automatic settle(input string req);
        int k = 0;
        while (k < 200 && !(src_idx == src_n && !arb_req && !out_valid)) begin
            step(); k++;
        end
        if (k >= 200) check_eq(req, "settle timeout", 1, 0);
        repeat (3) step();
    endtask

    function automatic int mism(input int base);
        int m = 0;
        for (int i = 0; i < pk_n; i++) if (obuf[8'(base + i)] != pk[i]) m++;
        return m;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int b_o, b_g, b_r, b_e;
        repeat (3) step();
        rst = 1'b0;
        step();
        check_eq("R1", "arb_req after reset", int'(arb_req), 0);
        check_eq("R1", "out_valid after reset", int'(out_valid), 0);
        check_eq("R1", "arb_release after reset", int'(arb_release), 0);
        check_eq("R1", "err_miss after reset", int'(err_miss), 0);
        // R1: table starts unmapped, so file 0 misses
        load_pkt(0, 1, 1, EOP);
        settle("R1");
        check_eq("R1", "miss count on fresh table", ecnt, 1);
        check_eq("R1", "no output on fresh table", out_cnt, 0);

        for (int f = 0; f < 16; f++) cfg_write(f, f < 12, port_of(f));

        // R12: lone marker with no open packet
        b_o = out_cnt; b_g = gcnt;
        src[8'(src_n)] = EOP; src_n++;
        repeat (3) step();
        check_eq("R12", "stray marker consumed", src_idx, src_n);
        check_eq("R12", "stray marker output", out_cnt - b_o, 0);
        check_eq("R12", "stray marker grants", gcnt - b_g, 0);

        for (int v = 0; v < 8; v++) begin
            int f, np;
            bit gd;
            f = int'(VEC[v][11:8]); np = int'(VEC[v][7:4]);
            gd = VEC[v][1]; tog = VEC[v][0];
            b_o = out_cnt; b_g = gcnt; b_r = rcnt; b_e = ecnt;
            if (gd) gnt_en = 1'b0;
            load_pkt(f, np, 2 + v, EOP);
            if (gd) begin
                repeat (4) step();
                check_eq("R4", "request held", int'(arb_req), 1);
                check_eq("R4", "no output before grant", int'(out_valid), 0);
                check_eq("R2", "dest while waiting", int'(arb_dest), int'(port_of(f)));
                gnt_en = 1'b1;
            end
            settle("R5");
            if (f < 12) begin
                check_eq("R2", "granted dest", int'(gdest), int'(port_of(f)));
                check_eq("R5", "token count", out_cnt - b_o, np + 2);
                check_eq("R5", "token mismatches", mism(b_o), 0);
                check_eq("R6", "release pulses", rcnt - b_r, 1);
            end else begin
                check_eq("R7", "miss pulses", ecnt - b_e, 1);
                check_eq("R7", "no output on miss", out_cnt - b_o, 0);
                check_eq("R7", "no grant on miss", gcnt - b_g, 0);
                check_eq("R7", "miss packet consumed", src_idx, src_n);
            end
            tog = 1'b0;
        end

        // R3: an incoming error-end marker is forwarded and closes
        b_o = out_cnt; b_r = rcnt;
        load_pkt(1, 2, 11, EEP);
        settle("R3");
        check_eq("R3", "error end forwarded", mism(b_o), 0);
        check_eq("R3", "last token", int'(obuf[8'(out_cnt - 1)]), int'(EEP));
        check_eq("R3", "release on error end", rcnt - b_r, 1);

        // R8: write in the lookup cycle still sees the old entry
        load_pkt(2, 1, 12, EOP);
        step();
        cfg_we = 1'b1; cfg_file = 4'd2; cfg_ok = 1'b1; cfg_port = 3'd6;
        step();
        cfg_we = 1'b0;
        settle("R8");
        check_eq("R8", "lookup-cycle write not used", int'(gdest), int'(port_of(2)));
        load_pkt(2, 1, 13, EOP);
        settle("R8");
        check_eq("R8", "next header uses new entry", int'(gdest), 6);

        // R8: rewrite mid-packet does not reroute
        b_o = out_cnt;
        stall_at = out_cnt + 2;
        load_pkt(4, 3, 14, EOP);
        while (out_cnt != stall_at) step();
        cfg_write(4, 1'b1, 3'd0);
        stall_at = -1;
        settle("R8");
        check_eq("R8", "in-flight dest kept", int'(gdest), int'(port_of(4)));
        check_eq("R8", "in-flight tokens intact", mism(b_o), 0);
        load_pkt(4, 0, 15, EOP);
        settle("R8");
        check_eq("R8", "rewritten dest used", int'(gdest), 0);

        // R9: abort while streaming and stalled
        b_o = out_cnt; b_r = rcnt;
        stall_at = out_cnt + 2;
        load_pkt(5, 4, 16, EOP);
        while (out_cnt != stall_at) step();
        sup_abort = 1'b1;
        step();
        sup_abort = 1'b0; stall_at = -1;
        settle("R9");
        check_eq("R9", "tokens before abort", out_cnt - b_o, 3);
        check_eq("R9", "header kept", int'(obuf[8'(b_o)]), int'(pk[0]));
        check_eq("R9", "error marker", int'(obuf[8'(b_o + 2)]), int'(EEP));
        check_eq("R9", "release after abort", rcnt - b_r, 1);
        check_eq("R9", "rest discarded", src_idx, src_n);

        // R10: abort on the end-marker handshake is ignored
        b_o = out_cnt; b_r = rcnt;
        stall_at = out_cnt + 2;
        load_pkt(6, 1, 17, EOP);
        while (!(out_cnt == stall_at && out_valid)) step();
        sup_abort = 1'b1; stall_at = -1;
        step();
        sup_abort = 1'b0;
        settle("R10");
        check_eq("R10", "normal end kept", out_cnt - b_o, 3);
        check_eq("R10", "tokens intact", mism(b_o), 0);
        check_eq("R10", "single release", rcnt - b_r, 1);

        // R11: abort while request waits, no grant
        b_o = out_cnt; b_r = rcnt; b_g = gcnt;
        gnt_en = 1'b0;
        load_pkt(7, 2, 18, EOP);
        repeat (3) step();
        check_eq("R11", "request up before abort", int'(arb_req), 1);
        sup_abort = 1'b1;
        step();
        sup_abort = 1'b0;
        check_eq("R11", "request withdrawn", int'(arb_req), 0);
        settle("R11");
        check_eq("R11", "no release", rcnt - b_r, 0);
        check_eq("R11", "no output", out_cnt - b_o, 0);
        check_eq("R11", "no grant", gcnt - b_g, 0);

        // R11: abort and grant in the same cycle
        b_o = out_cnt; b_r = rcnt;
        load_pkt(8, 2, 19, EOP);
        repeat (3) step();
        sup_abort = 1'b1; gnt_en = 1'b1;
        step();
        sup_abort = 1'b0;
        settle("R11");
        check_eq("R11", "only error marker", out_cnt - b_o, 1);
        check_eq("R11", "marker value", int'(obuf[8'(b_o)]), int'(EEP));
        check_eq("R11", "release after grant abort", rcnt - b_r, 1);
        check_eq("R11", "packet discarded", src_idx, src_n);

        // R6: block accepts a fresh packet afterwards
        b_o = out_cnt;
        load_pkt(9, 1, 20, EOP);
        settle("R6");
        check_eq("R6", "next packet after aborts", mism(b_o), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule